// File: doc/BRIEF.md
# Immediate Extension Prefix Combiner

This block sits beside an instruction decoder and widens short operands. Up to two 13-bit prefix words can arrive ahead of an instruction that accepts wider operands, and the block holds them. When the instruction shows up, the block joins the held prefixes to the instruction's short immediate and returns a 24-bit operand.

The joining rule depends on the operand kind and on how many prefixes are held. There are three kinds: a 7-bit signed relative displacement (stored with an implied zero as its least significant bit), a 10-bit signed relative displacement (also with an implied zero LSB), and a 7-bit absolute address. Each accepted instruction consumes the held prefixes. The block flags prefix overruns and combinations it does not support.

The merge is combinational in the same cycle as the instruction strobe. Only the prefix store is registered. Reset is asserted asynchronously and released in step with the clock.

Top module: `ext_prefix_merge`

## Requirements
- R1: For kind 0 (7-bit relative), the result depends on how many prefixes are held:
  - none: the result is {s7, 0}, sign-extended from bit 7;
  - one prefix P: the result is {P, s7, 0}, sign-extended from bit 20;
  - two prefixes F then S: the result is {F[2:0], S, s7, 0}.
  - Immediate bits 9:7 are ignored for this kind.
- R2: For kind 1 (10-bit relative), no prefix gives {s10, 0} sign-extended from bit 10, and one prefix P gives {P, s10, 0}.
- R3: For kind 2 (7-bit absolute), the result depends on how many prefixes are held:
  - none: the 7-bit immediate, zero-extended;
  - one prefix P: {P, a7}, sign-extended from bit 19;
  - two prefixes F then S: {F[3:0], S, a7}.
- R4: `opnd_valid_o` follows `ins_valid_i` in the same cycle. While `ins_valid_i` is low, `opnd_o` is zero.
- R5: The cycle that accepts an instruction clears every held prefix. A later instruction with no new prefix sees none.
- R6: A prefix that arrives while two are already held raises `pfx_overrun_o` in that cycle. The oldest prefix is dropped, and the two most recent are kept in arrival order.
- R7: Kind 1 with two prefixes held raises `combo_unsup_o`. The operand is then built from the most recent prefix alone, as in the one-prefix case.
- R8: Kind 3 is reserved. It raises `combo_unsup_o` and yields a zero operand.
- R9: A prefix strobe in the same cycle as an instruction strobe is ignored and is not stored.
- R10: Reset clears the held prefixes, and all outputs read zero while no instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfx_valid_i | input | 1 | A prefix word is presented this cycle |
| pfx_imm_i | input | 13 | Prefix immediate |
| ins_valid_i | input | 1 | An extendable instruction is presented this cycle |
| ins_kind_i | input | 2 | Operand kind: 0 rel7, 1 rel10, 2 abs7, 3 reserved |
| ins_imm_i | input | 10 | Short immediate of the instruction |
| opnd_o | output | 24 | Widened operand |
| opnd_valid_o | output | 1 | Operand is valid |
| pfx_overrun_o | output | 1 | A third consecutive prefix arrived |
| combo_unsup_o | output | 1 | The kind and prefix count combination is not supported |

## Verification
Each kind is driven with zero, one and two prefixes. The inputs include values whose sign bit is clear and values whose sign bit is set, so an extension taken from the wrong bit position gives a visible error. The two-prefix cases put distinct marker bits in the low bits of the first prefix and also set bits above the field that is kept, which reveals a field taken from the wrong slot or with the wrong width. Directed sequences cover three prefixes in a row, a prefix strobe that coincides with an instruction, the reserved kind, a 10-bit displacement with two prefixes, and a reset that arrives while a prefix is held.

// File: rtl/ext_pkg.sv
package ext_pkg;
  localparam int unsigned MAX_PFX = 2;
  localparam int unsigned SHORT_W = 7;
  localparam int unsigned LONG_W  = 10;

  typedef enum logic [1:0] {
    KIND_REL7  = 2'd0,
    KIND_REL10 = 2'd1,
    KIND_ABS7  = 2'd2,
    KIND_RSVD  = 2'd3
  } opnd_kind_e;
endpackage

// File: rtl/ext_prefix_store.sv
module ext_prefix_store #(
  parameter int unsigned PFX_W = 13,
  parameter int unsigned SLOTS = 2,
  parameter int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             clear_i,
  input  logic [PFX_W-1:0] imm_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PFX_W-1:0] slot_o [SLOTS],
  output logic             overrun_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PFX_W-1:0] slot_q [SLOTS];
  logic [PFX_W-1:0] slot_d [SLOTS];
  logic             full;
  logic             upd_en;

  assign full      = (cnt_q == FULL);
  assign upd_en    = push_i | clear_i;
  assign overrun_o = push_i & ~clear_i & full;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (push_i && !full) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_comb begin
      slot_d[g] = slot_q[g];
      if (clear_i) begin
        slot_d[g] = '0;
      end else if (push_i) begin
        if (full) begin
          if (g == SLOTS - 1) begin
            slot_d[g] = imm_i;
          end else begin
            slot_d[g] = slot_q[(g + 1) % SLOTS];
          end
        end else if (cnt_q == CNT_W'(g)) begin
          slot_d[g] = imm_i;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (upd_en) begin
        slot_q[g] <= slot_d[g];
      end
    end

    assign slot_o[g] = slot_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ext_operand_merge.sv
module ext_operand_merge
  import ext_pkg::*;
#(
  parameter int unsigned PFX_W = 13,
  parameter int unsigned IMM_W = 10,
  parameter int unsigned OUT_W = 24,
  parameter int unsigned CNT_W = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PFX_W-1:0] first_i,
  input  logic [PFX_W-1:0] second_i,
  input  opnd_kind_e       kind_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [OUT_W-1:0] opnd_o,
  output logic             unsup_o
);
  localparam int unsigned R7_HI  = OUT_W - PFX_W - SHORT_W - 1;
  localparam int unsigned A7_HI  = OUT_W - PFX_W - SHORT_W;
  localparam int unsigned R7_SH  = SHORT_W + 1;
  localparam int unsigned R10_SH = LONG_W + 1;

  function automatic logic [OUT_W-1:0] sext_at(input logic [OUT_W-1:0] v,
                                               input int unsigned msb);
    logic [OUT_W-1:0] r;
    r = v;
    for (int b = 0; b < OUT_W; b++) begin
      if (b > msb) r[b] = v[msb];
    end
    return r;
  endfunction

  logic [OUT_W-1:0] near7, near10, abs7;
  logic [OUT_W-1:0] rel7_0, rel7_1, rel7_2;
  logic [OUT_W-1:0] rel10_0, rel10_1, rel10_2;
  logic [OUT_W-1:0] abs7_0, abs7_1, abs7_2;

  assign near7  = OUT_W'({imm_i[SHORT_W-1:0], 1'b0});
  assign near10 = OUT_W'({imm_i[LONG_W-1:0], 1'b0});
  assign abs7   = OUT_W'(imm_i[SHORT_W-1:0]);

  assign rel7_0 = sext_at(near7, SHORT_W);
  assign rel7_1 = sext_at((OUT_W'(first_i) << R7_SH) | near7, PFX_W + SHORT_W);
  assign rel7_2 = (OUT_W'(first_i[R7_HI-1:0]) << (PFX_W + R7_SH))
                | (OUT_W'(second_i) << R7_SH) | near7;

  assign rel10_0 = sext_at(near10, LONG_W);
  assign rel10_1 = sext_at((OUT_W'(first_i) << R10_SH) | near10, PFX_W + LONG_W);
  assign rel10_2 = sext_at((OUT_W'(second_i) << R10_SH) | near10, PFX_W + LONG_W);

  assign abs7_0 = abs7;
  assign abs7_1 = sext_at((OUT_W'(first_i) << SHORT_W) | abs7, PFX_W + SHORT_W - 1);
  assign abs7_2 = (OUT_W'(first_i[A7_HI-1:0]) << (PFX_W + SHORT_W))
                | (OUT_W'(second_i) << SHORT_W) | abs7;

  always_comb begin
    opnd_o  = '0;
    unsup_o = 1'b0;
    case (kind_i)
      KIND_REL7: begin
        case (cnt_i)
          CNT_W'(0): opnd_o = rel7_0;
          CNT_W'(1): opnd_o = rel7_1;
          default:   opnd_o = rel7_2;
        endcase
      end
      KIND_REL10: begin
        case (cnt_i)
          CNT_W'(0): opnd_o = rel10_0;
          CNT_W'(1): opnd_o = rel10_1;
          default: begin
            opnd_o  = rel10_2;
            unsup_o = 1'b1;
          end
        endcase
      end
      KIND_ABS7: begin
        case (cnt_i)
          CNT_W'(0): opnd_o = abs7_0;
          CNT_W'(1): opnd_o = abs7_1;
          default:   opnd_o = abs7_2;
        endcase
      end
      default: begin
        opnd_o  = '0;
        unsup_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ext_prefix_merge.sv
module ext_prefix_merge
  import ext_pkg::*;
#(
  parameter int unsigned PFX_W = 13,
  parameter int unsigned IMM_W = 10,
  parameter int unsigned OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfx_valid_i,
  input  logic [PFX_W-1:0] pfx_imm_i,
  input  logic             ins_valid_i,
  input  logic [1:0]       ins_kind_i,
  input  logic [IMM_W-1:0] ins_imm_i,
  output logic [OUT_W-1:0] opnd_o,
  output logic             opnd_valid_o,
  output logic             pfx_overrun_o,
  output logic             combo_unsup_o
);
  localparam int unsigned CNT_W = $clog2(MAX_PFX + 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             push;
  logic [CNT_W-1:0] pfx_cnt;
  logic [PFX_W-1:0] slots [MAX_PFX];
  logic [OUT_W-1:0] merged;
  logic             unsup;
  logic             overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign push = pfx_valid_i & ~ins_valid_i;

  ext_prefix_store #(
    .PFX_W (PFX_W),
    .SLOTS (MAX_PFX),
    .CNT_W (CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (push),
    .clear_i   (ins_valid_i),
    .imm_i     (pfx_imm_i),
    .cnt_o     (pfx_cnt),
    .slot_o    (slots),
    .overrun_o (overrun)
  );

  ext_operand_merge #(
    .PFX_W (PFX_W),
    .IMM_W (IMM_W),
    .OUT_W (OUT_W),
    .CNT_W (CNT_W)
  ) u_merge (
    .cnt_i    (pfx_cnt),
    .first_i  (slots[0]),
    .second_i (slots[MAX_PFX-1]),
    .kind_i   (opnd_kind_e'(ins_kind_i)),
    .imm_i    (ins_imm_i),
    .opnd_o   (merged),
    .unsup_o  (unsup)
  );

  assign opnd_o        = ins_valid_i ? merged : '0;
  assign opnd_valid_o  = ins_valid_i;
  assign combo_unsup_o = ins_valid_i & unsup;
  assign pfx_overrun_o = overrun;
endmodule

// File: rtl/ext_prefix_merge_chk.sv
module ext_prefix_merge_chk #(
  parameter int unsigned OUT_W = 24,
  parameter int unsigned CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pfx_valid_i,
  input logic             ins_valid_i,
  input logic [OUT_W-1:0] opnd_o,
  input logic             opnd_valid_o,
  input logic             pfx_overrun_o,
  input logic             combo_unsup_o,
  input logic [CNT_W-1:0] pfx_cnt
);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_cnt <= CNT_W'(2));

  assert_clear_after_ins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_i |=> (pfx_cnt == '0));

  assert_ignore_coincident_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_valid_i && ins_valid_i) |=> (pfx_cnt == '0));

  assert_overrun_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_overrun_o |-> (pfx_cnt == CNT_W'(2)) && pfx_valid_i && !ins_valid_i);

  assert_overrun_stays_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_overrun_o |=> (pfx_cnt == CNT_W'(2)));

  assert_unsup_with_ins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    combo_unsup_o |-> ins_valid_i);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid_i |-> (opnd_o == '0) && !opnd_valid_o && !combo_unsup_o);
endmodule

bind ext_prefix_merge ext_prefix_merge_chk #(
  .OUT_W (OUT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .pfx_valid_i   (pfx_valid_i),
  .ins_valid_i   (ins_valid_i),
  .opnd_o        (opnd_o),
  .opnd_valid_o  (opnd_valid_o),
  .pfx_overrun_o (pfx_overrun_o),
  .combo_unsup_o (combo_unsup_o),
  .pfx_cnt       (pfx_cnt)
);

// File: tb/test_ext_prefix_merge.sv
module test_ext_prefix_merge;
  logic        clk;
  logic        rst_n;
  logic        pfx_valid;
  logic [12:0] pfx_imm;
  logic        ins_valid;
  logic [1:0]  ins_kind;
  logic [9:0]  ins_imm;
  logic [23:0] opnd;
  logic        opnd_valid;
  logic        overrun;
  logic        unsup;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  ext_prefix_merge i_ext_prefix_merge (
    .clk           (clk),
    .rst_n         (rst_n),
    .pfx_valid_i   (pfx_valid),
    .pfx_imm_i     (pfx_imm),
    .ins_valid_i   (ins_valid),
    .ins_kind_i    (ins_kind),
    .ins_imm_i     (ins_imm),
    .opnd_o        (opnd),
    .opnd_valid_o  (opnd_valid),
    .pfx_overrun_o (overrun),
    .combo_unsup_o (unsup)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {count[63:62], first[61:49], second[48:36], kind[35:34], imm[33:24], expected[23:0]}
  localparam int NVEC = 13;
  localparam logic [63:0] VEC [NVEC] = '{
    {2'd0, 13'h0000, 13'h0000, 2'd0, 10'h385, 24'h00000A},
    {2'd0, 13'h0000, 13'h0000, 2'd0, 10'h040, 24'hFFFF80},
    {2'd1, 13'h0001, 13'h0000, 2'd0, 10'h001, 24'h000102},
    {2'd1, 13'h1000, 13'h0000, 2'd0, 10'h000, 24'hF00000},
    {2'd2, 13'h0005, 13'h0003, 2'd0, 10'h07F, 24'hA003FE},
    {2'd0, 13'h0000, 13'h0000, 2'd1, 10'h1FF, 24'h0003FE},
    {2'd0, 13'h0000, 13'h0000, 2'd1, 10'h200, 24'hFFFC00},
    {2'd1, 13'h0ABC, 13'h0000, 2'd1, 10'h123, 24'h55E246},
    {2'd0, 13'h0000, 13'h0000, 2'd2, 10'h3FF, 24'h00007F},
    {2'd1, 13'h0123, 13'h0000, 2'd2, 10'h045, 24'h0091C5},
    {2'd1, 13'h1FFF, 13'h0000, 2'd2, 10'h000, 24'hFFFF80},
    {2'd2, 13'h00F6, 13'h1555, 2'd2, 10'h02A, 24'h6AAAAA},
    {2'd2, 13'h1FF3, 13'h0000, 2'd2, 10'h001, 24'h300001}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_pfx(input logic [12:0] v, output logic ovr);
    pfx_valid = 1'b1;
    pfx_imm   = v;
    #2 ovr = overrun;
    @(posedge clk);
    #1 pfx_valid = 1'b0;
  endtask

  task automatic send_ins(input logic [1:0] k, input logic [9:0] imm,
                          output logic [23:0] res, output logic vld, output logic uns);
    ins_valid = 1'b1;
    ins_kind  = k;
    ins_imm   = imm;
    #2;
    res = opnd;
    vld = opnd_valid;
    uns = unsup;
    @(posedge clk);
    #1 ins_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] res;
    logic vld, uns, ovr;
    string tag;
    pfx_valid = 0; pfx_imm = '0; ins_valid = 0; ins_kind = '0; ins_imm = '0;
    do_reset();

    // R10: outputs idle after reset
    #2;
    check("R10 idle operand", opnd, 24'h0);
    check("R10 idle flags", {22'h0, unsup, overrun}, 24'h0);

    // Table walk: R1 / R2 / R3 by kind; also R4 valid and R5 clearing between entries
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v;
      v = VEC[i];
      tag = (v[35:34] == 2'd0) ? "R1" : (v[35:34] == 2'd1) ? "R2" : "R3";
      if (v[63:62] >= 2'd1) send_pfx(v[61:49], ovr);
      if (v[63:62] == 2'd2) send_pfx(v[48:36], ovr);
      send_ins(v[35:34], v[33:24], res, vld, uns);
      check($sformatf("%s vector %0d", tag, i), res, v[23:0]);
      check($sformatf("R4 valid vector %0d", i), {23'h0, vld}, 24'h1);
    end

    // R5: a prefixed instruction followed by a bare one sees no prefix
    send_pfx(13'h1ABC, ovr);
    send_ins(2'd2, 10'h011, res, vld, uns);
    send_ins(2'd2, 10'h011, res, vld, uns);
    check("R5 bare after prefixed", res, 24'h000011);

    // R6: three prefixes, oldest dropped
    send_pfx(13'h0001, ovr);
    check("R6 no overrun on first", {23'h0, ovr}, 24'h0);
    send_pfx(13'h0002, ovr);
    check("R6 no overrun on second", {23'h0, ovr}, 24'h0);
    send_pfx(13'h0003, ovr);
    check("R6 overrun on third", {23'h0, ovr}, 24'h1);
    send_ins(2'd0, 10'h000, res, vld, uns);
    check("R6 keeps two newest", res, 24'h400300);

    // R7: rel10 with two prefixes uses the newest alone
    send_pfx(13'h1111, ovr);
    send_pfx(13'h0002, ovr);
    send_ins(2'd1, 10'h000, res, vld, uns);
    check("R7 operand", res, 24'h001000);
    check("R7 flag", {23'h0, uns}, 24'h1);

    // R8: reserved kind
    send_pfx(13'h0055, ovr);
    send_ins(2'd3, 10'h3FF, res, vld, uns);
    check("R8 operand", res, 24'h0);
    check("R8 flag", {23'h0, uns}, 24'h1);

    // R9: coincident prefix is not stored
    pfx_valid = 1'b1;
    pfx_imm   = 13'h1FFF;
    send_ins(2'd2, 10'h005, res, vld, uns);
    pfx_valid = 1'b0;
    check("R9 coincident operand", res, 24'h000005);
    send_ins(2'd2, 10'h005, res, vld, uns);
    check("R9 nothing stored", res, 24'h000005);

    // R10: reset while a prefix is held
    send_pfx(13'h0FFF, ovr);
    do_reset();
    send_ins(2'd2, 10'h003, res, vld, uns);
    check("R10 reset drops prefix", res, 24'h000003);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule